// File: doc/BRIEF.md
# Indirect memory access controller

This block lets a host processor reach a 9-bit internal address space through a small window of four byte-wide host registers. That space holds the control registers, the connection memory and the data memory. The host first sets a location by writing the low address byte. It then writes the mode byte, which carries the top address bit, the memory select and the stepping rule. After that it moves data through the data register. A write to the data register issues a write request on the memory side. A read of it returns a value that the controller fetched in advance from the current location.

The memory side is a plain request/acknowledge handshake: the controller holds a request with its address, select, direction and write data until the memory acknowledges it. While a request is outstanding the controller raises `busy`, and the host bus front end uses that to stretch its cycle. After each completed data access the address may move up or down by one, wrapping within the 512-location space. The host can read the new address back from the address registers.

Top module: `ixa_ctrl`

## Requirements
- R1: While reset is high, the low address register, the mode register and the read buffer are cleared. After reset, `busy` and `mem_req` are low and all three registers read back as zero.
- R2: Host offsets are 0 for the low address (read/write), 1 for the mode register, 2 for the data register and 3 for a reserved location. The mode register is read/write in bits 4:0, and its bits 7:5 read back as zero. Offset 3 reads as zero, and writes to it change nothing.
- R3: Mode register fields: bit 0 is address bit 8; bits 2:1 are the memory select (00 control, 01 connection, 10 data; 11 is passed to `mem_sel` unchanged); bits 4:3 are the step rule (00 hold, 01 increment, 10 decrement, 11 hold). The current address is {mode bit 0, low address}, and it is driven on `mem_addr` at all times.
- R4: A mode register write accepted while idle starts a fetch in the next cycle: `mem_req`=1, `mem_we`=0, with the new address and select.
- R5: A read of the data register returns the `mem_rdata` value latched when the most recent fetch was acknowledged.
- R6: A data register write accepted while idle raises, in the next cycle, a request with `mem_we`=1 and that byte on `mem_wdata`. After its acknowledge, a fetch of the (possibly stepped) current address follows in the next cycle.
- R7: After a data register read accepted while idle, or after an acknowledged data write, the 9-bit address steps according to the step rule, modulo 512. The address registers read back the new value. A read under increment or decrement starts a fetch of the new address.
- R8: `busy` is high exactly while a request is outstanding. Host writes made while busy are ignored, and data register reads made while busy do not step the address.
- R9: A request that has not been acknowledged is held the next cycle with address, select, direction and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read, qualified by host_cs |
| host_ofs | input | 2 | Host register offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data of the register at host_ofs |
| busy | output | 1 | Request outstanding; host front end stretches its cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request direction, 1 = write |
| mem_sel | output | 2 | Memory select field |
| mem_addr | output | 9 | Current indirect address |
| mem_wdata | output | DATA_W | Write data of a write request |
| mem_ack | input | 1 | Memory acknowledge, completes the request in that cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack on a fetch |

## Verification
The hardest situation to reach from the ports is a host access that arrives while a request is still pending. A well-behaved host waits on `busy`, so such accesses never occur in normal traffic. The bench makes the memory model acknowledge late on purpose. It then writes an address register and reads the data register under increment inside that window, and checks that neither the address nor the buffered data moved. The two wrap points, 511 stepping up and 0 stepping down, are also exercised, because they cross into and out of the mode register's address bit. Random traffic with acknowledge delays of zero to three cycles covers the rest.

// File: rtl/ixa_pkg.sv
package ixa_pkg;

    localparam int ADDR_W = 9;
    localparam int LOW_W  = ADDR_W - 1;
    localparam int MODE_W = 5;

    localparam logic [1:0] OFS_LOW  = 2'd0;
    localparam logic [1:0] OFS_MODE = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CONN = 2'd1,
        SEL_DMEM = 2'd2,
        SEL_RSVD = 2'd3
    } mem_sel_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_RSVD = 2'd3
    } step_e;

    // packed from MSB: step[4:3], select[2:1], address bit 8 [0]
    typedef struct packed {
        step_e    step;
        mem_sel_e sel;
        logic     addr_hi;
    } mode_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_STORE = 2'd2
    } sq_state_e;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                     input step_e s);
        case (s)
            STEP_UP:   step_addr = a + 1'b1;
            STEP_DOWN: step_addr = a - 1'b1;
            default:   step_addr = a;
        endcase
    endfunction

    function automatic logic is_moving(input step_e s);
        is_moving = (s == STEP_UP) || (s == STEP_DOWN);
    endfunction

endpackage

// File: rtl/ixa_hostregs.sv
module ixa_hostregs
    import ixa_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_wr,
    input  logic [1:0]        host_ofs,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              adv,
    input  logic [DATA_W-1:0] rbuf,
    output logic [DATA_W-1:0] host_rdata,
    output mode_t             mode,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mode_wr_go,
    output logic              data_wr_go,
    output logic              data_rd_go
);

    logic [LOW_W-1:0] low_q;
    mode_t            mode_q;
    logic             accept;

    assign accept     = host_cs && !busy;
    assign mode_wr_go = accept && host_wr && (host_ofs == OFS_MODE);
    assign data_wr_go = accept && host_wr && (host_ofs == OFS_DATA);
    assign data_rd_go = accept && !host_wr && (host_ofs == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q  <= '0;
            mode_q <= '0;
        end else if (adv) begin
            {mode_q.addr_hi, low_q} <= step_addr({mode_q.addr_hi, low_q}, mode_q.step);
        end else if (accept && host_wr) begin
            case (host_ofs)
                OFS_LOW:  low_q  <= host_wdata[LOW_W-1:0];
                OFS_MODE: mode_q <= mode_t'(host_wdata[MODE_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_ofs)
            OFS_LOW:  host_rdata[LOW_W-1:0]  = low_q;
            OFS_MODE: host_rdata[MODE_W-1:0] = mode_q;
            OFS_DATA: host_rdata             = rbuf;
            default:  host_rdata             = '0;
        endcase
    end

    assign mode     = mode_q;
    assign cur_addr = {mode_q.addr_hi, low_q};

endmodule

// File: rtl/ixa_seq.sv
module ixa_seq
    import ixa_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr_go,
    input  logic              data_wr_go,
    input  logic              data_rd_go,
    input  step_e             step,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rbuf,
    output logic              adv
);

    sq_state_e         st_q;
    logic [DATA_W-1:0] wbuf_q;
    logic [DATA_W-1:0] rbuf_q;

    assign busy      = (st_q != SQ_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (st_q == SQ_STORE);
    assign mem_wdata = wbuf_q;
    assign rbuf      = rbuf_q;
    assign adv       = data_rd_go || ((st_q == SQ_STORE) && mem_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            wbuf_q <= '0;
            rbuf_q <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (mode_wr_go) begin
                        st_q <= SQ_FETCH;
                    end else if (data_wr_go) begin
                        wbuf_q <= host_wdata;
                        st_q   <= SQ_STORE;
                    end else if (data_rd_go && is_moving(step)) begin
                        st_q <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    if (mem_ack) begin
                        rbuf_q <= mem_rdata;
                        st_q   <= SQ_IDLE;
                    end
                end
                SQ_STORE: begin
                    if (mem_ack) st_q <= SQ_FETCH;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ixa_ctrl.sv
module ixa_ctrl
    import ixa_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_wr,
    input  logic [1:0]        host_ofs,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_sel,
    output logic [8:0]        mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    mode_t             mode_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              mode_wr_go;
    logic              data_wr_go;
    logic              data_rd_go;
    logic              adv;
    logic [DATA_W-1:0] rbuf;

    ixa_hostregs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_cs    (host_cs),
        .host_wr    (host_wr),
        .host_ofs   (host_ofs),
        .host_wdata (host_wdata),
        .busy       (busy),
        .adv        (adv),
        .rbuf       (rbuf),
        .host_rdata (host_rdata),
        .mode       (mode_q),
        .cur_addr   (cur_addr),
        .mode_wr_go (mode_wr_go),
        .data_wr_go (data_wr_go),
        .data_rd_go (data_rd_go)
    );

    ixa_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode_wr_go (mode_wr_go),
        .data_wr_go (data_wr_go),
        .data_rd_go (data_rd_go),
        .step       (mode_q.step),
        .host_wdata (host_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .rbuf       (rbuf),
        .adv        (adv)
    );

    assign mem_addr = cur_addr;
    assign mem_sel  = mode_q.sel;

endmodule

// File: rtl/ixa_ctrl_chk.sv
module ixa_ctrl_chk
    import ixa_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_cs,
    input logic              host_wr,
    input logic [1:0]        host_ofs,
    input logic [DATA_W-1:0] host_wdata,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [1:0]        mem_sel,
    input logic [8:0]        mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [1:0]        step_mode
);

    // R1: reset leaves the controller idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!mem_req && !busy));

    // R4: an accepted mode write launches a fetch with the new fields
    p_mode_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        (host_cs && host_wr && host_ofs == OFS_MODE && !busy)
        |=> (mem_req && !mem_we && mem_sel == $past(host_wdata[2:1])
             && mem_addr[8] == $past(host_wdata[0])));

    // R6: an accepted data write launches a write request with that byte
    p_store_req_r6: assert property (@(posedge clk) disable iff (rst)
        (host_cs && host_wr && host_ofs == OFS_DATA && !busy)
        |=> (mem_req && mem_we && mem_wdata == $past(host_wdata)));

    // R6: an acknowledged write is followed by a fetch
    p_store_refetch_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R7: increment after an acknowledged write, modulo 512
    p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && step_mode == STEP_UP)
        |=> (mem_addr == $past(mem_addr) + 9'd1));

    // R8: address register writes made while busy are dropped
    p_busy_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack && host_cs && host_wr && host_ofs != OFS_DATA)
        |=> $stable(mem_addr));

    // R9: a pending request is held unchanged
    p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
             && $stable(mem_sel) && $stable(mem_wdata)));

endmodule

bind ixa_ctrl ixa_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_cs    (host_cs),
    .host_wr    (host_wr),
    .host_ofs   (host_ofs),
    .host_wdata (host_wdata),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_sel    (mem_sel),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .step_mode  (mode_q.step)
);

// File: tb/test_ixa_ctrl.sv
module test_ixa_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_cs = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_ofs = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       busy;
    logic       mem_req;
    logic       mem_we;
    logic [1:0] mem_sel;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_ack = 1'b0;
    logic [7:0] mem_rdata = 8'd0;

    always #10 clk = ~clk;

    ixa_ctrl #(.DATA_W(8)) i_ixa_ctrl (
        .clk(clk), .rst(rst), .host_cs(host_cs), .host_wr(host_wr),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mdl  [4][512];
    logic [7:0] expm [4][512];
    logic [8:0] e_addr = 9'd0;
    logic [1:0] e_sel = 2'd0;
    logic [1:0] e_step = 2'd0;
    bit slow = 1'b0;
    int cnt = 0;
    int tgt = 0;
    bit done = 1'b0;

    // memory model: acknowledges after a random delay
    always @(negedge clk) begin
        if (rst || !mem_req) begin
            mem_ack <= 1'b0;
            cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            cnt <= 0;
            tgt <= $urandom % 4;
        end else if (cnt >= (slow ? 8 : tgt)) begin
            mem_ack <= 1'b1;
            mem_rdata <= mdl[mem_sel][mem_addr];
        end else begin
            cnt <= cnt + 1;
        end
    end

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack && mem_we)
            mdl[mem_sel][mem_addr] <= mem_wdata;
    end

    function automatic logic [8:0] f_step(input logic [8:0] a, input logic [1:0] s);
        if (s == 2'd1) return a + 9'd1;
        if (s == 2'd2) return a - 9'd1;
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] o, input logic [7:0] d);
        host_cs = 1'b1; host_wr = 1'b1; host_ofs = o; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] o, output logic [7:0] d);
        host_cs = 1'b1; host_wr = 1'b0; host_ofs = o;
        #1 d = host_rdata;
        @(negedge clk);
        host_cs = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic set_addr(input logic [8:0] a, input logic [1:0] sel, input logic [1:0] st);
        wait_idle();
        wr(2'd0, a[7:0]);
        wr(2'd1, {3'b000, st, sel, a[8]});
        e_addr = a; e_sel = sel; e_step = st;
    endtask

    task automatic do_read(input string req);
        logic [7:0] v;
        wait_idle();
        rd(2'd2, v);
        chk(v == expm[e_sel][e_addr], req, v, expm[e_sel][e_addr]);
        e_addr = f_step(e_addr, e_step);
    endtask

    task automatic do_write(input logic [7:0] d);
        wait_idle();
        wr(2'd2, d);
        expm[e_sel][e_addr] = d;
        e_addr = f_step(e_addr, e_step);
        wait_idle();
    endtask

    task automatic chk_addr(input string req);
        logic [7:0] lo;
        logic [7:0] md;
        wait_idle();
        rd(2'd0, lo);
        rd(2'd1, md);
        chk({md[0], lo} == e_addr, req, {md[0], lo}, e_addr);
        chk(md == {3'b000, e_step, e_sel, e_addr[8]}, req, md, {3'b000, e_step, e_sel, e_addr[8]});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        logic [8:0] held;
        void'($urandom(32'h1bad5eed));
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 512; a++) begin
                mdl[s][a]  = 8'($urandom);
                expm[s][a] = mdl[s][a];
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);
        rd(2'd0, v); chk(v == 8'd0, "R1 low address", v, 0);
        rd(2'd1, v); chk(v == 8'd0, "R1 mode", v, 0);
        rd(2'd2, v); chk(v == 8'd0, "R1 read buffer", v, 0);

        // R2: reserved offset and mode upper bits
        set_addr(9'h123, 2'd1, 2'd0);
        wait_idle();
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk(v == 8'd0, "R2 reserved offset reads zero", v, 0);
        chk_addr("R2 reserved write no effect");
        wait_idle();
        wr(2'd1, 8'hFF);
        e_addr[8] = 1'b1; e_sel = 2'd3; e_step = 2'd3;
        // R3: select 11 passed through on the fetch
        chk(mem_req && !mem_we && mem_sel == 2'd3, "R3 select 11 on fetch", mem_sel, 3);
        rd(2'd1, v); chk(v == 8'h1F, "R2 mode upper bits zero", v, 8'h1F);
        do_read("R3 step 11 holds");
        chk_addr("R3 step 11 holds address");

        // R4: fetch launched by mode write
        set_addr(9'h1A5, 2'd2, 2'd1);
        chk(mem_req && !mem_we && mem_addr == 9'h1A5 && mem_sel == 2'd2,
            "R4 fetch after mode write", mem_addr, 9'h1A5);
        do_read("R5 prefetched data");
        chk_addr("R7 increment after read");
        do_read("R7 prefetch of stepped address");

        // R6: write request and refetch
        set_addr(9'd300, 2'd2, 2'd2);
        wait_idle();
        wr(2'd2, 8'h5C);
        chk(mem_req && mem_we && mem_wdata == 8'h5C && mem_addr == 9'd300,
            "R6 write request", mem_wdata, 8'h5C);
        expm[2][300] = 8'h5C;
        e_addr = 9'd299;
        wait_idle();
        chk_addr("R7 decrement after write");
        set_addr(9'd300, 2'd2, 2'd0);
        do_read("R6 written value read back");
        do_write(8'hA7);
        do_read("R6 refetch after write without step");

        // R7: wrap points
        set_addr(9'd511, 2'd0, 2'd1);
        do_read("R7 read at 511");
        chk_addr("R7 wrap up to 0");
        set_addr(9'd0, 2'd1, 2'd2);
        do_write(8'h3E);
        chk_addr("R7 wrap down to 511");

        // R8 / R9: accesses during a slow request
        slow = 1'b1;
        set_addr(9'd10, 2'd1, 2'd1);
        held = mem_addr;
        chk(busy && mem_req, "R8 busy while pending", busy, 1);
        rd(2'd2, v);
        wr(2'd0, 8'hAA);
        wr(2'd1, 8'h04);
        chk(busy && mem_addr == held && !mem_we, "R9 request held", mem_addr, held);
        slow = 1'b0;
        chk_addr("R8 busy accesses ignored");
        do_read("R8 buffer after busy accesses");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 8;
            if (op == 0)
                set_addr(9'($urandom), 2'($urandom % 3), 2'($urandom % 4));
            else if (op < 5)
                do_read("R5 random read");
            else
                do_write(8'($urandom));
            if (i % 25 == 0) chk_addr("R7 random address readback");
        end

        // R1: reset mid-run
        wait_idle();
        wr(2'd2, 8'h11);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !mem_req, "R1 reset aborts request", {busy, mem_req}, 0);
        rd(2'd0, v); chk(v == 8'd0, "R1 low address after reset", v, 0);
        rd(2'd1, v); chk(v == 8'd0, "R1 mode after reset", v, 0);

        done = 1'b1;
        finish_run();
    end

endmodule